// File: doc/BRIEF.md
# Receive Payload Serial/Nibble Output Stage

This block sits at the system-side edge of a DS3/E3 receive path. It takes a recovered bit stream, one bit at a time, together with a per-bit overhead mask and a frame-start flag. It presents the bits either one at a time on a serial data line or packed four at a time on a nibble bus. With the data it drives a frame indicator, an output data clock and one shared pin. In normal operation the shared pin marks overhead. In gapped-clock mode it carries a clock that pulses only for payload bits, so downstream equipment can latch payload on its falling edge without decoding the frame.

The block runs on a clock at twice the bit rate. Each bit is offered with `inValid` high for one cycle, and bits arrive every second cycle. All outputs are registers updated on the rising clock edge, so they can be sampled on the falling edge. The output data clock and the gapped clock are also registered waveforms and have no gating logic. Nothing is presented until the first frame-start flag arrives. A frame-start flag also fixes the nibble alignment.

Configuration encodings: `cfgE3` = 1 selects E3 and 0 selects DS3. `cfgNibble` = 1 selects the nibble bus and 0 selects serial. `cfgGapped` = 1 selects the gapped clock on the shared pin. Configuration is changed only while reset is held.

Top module: `rx_payload_out`

## Requirements
- R1: While reset is asserted, `serData`, `nibData`, `frameInd`, `ohPin` and `dataClk` are all 0.
- R2: Bits offered before the first bit carrying `inSof` = 1 are ignored, and all outputs stay 0. The bit that carries `inSof` is the first one accepted.
- R3: Serial mode: on the rising edge that captures an accepted bit, `serData` takes that bit and holds it for two cycles. `dataClk` is 1 in the first cycle and 0 in the second.
- R4: Serial mode: `frameInd` equals the frame-start flag of the bit currently on `serData`, and holds it for the whole bit period.
- R5: Serial mode, non-gapped, for both DS3 and E3: `ohPin` equals the overhead flag of the bit currently on `serData`, and holds it for the whole bit period.
- R6: Serial mode, gapped: `ohPin` is 1 only in the first cycle of a payload bit. It is 0 in the second cycle, and 0 in both cycles of an overhead bit.
- R7: Nibble mode: four accepted bits form a nibble, with the earliest bit on `nibData[3]` and the latest on `nibData[0]`. The nibble appears on the edge that captures its fourth bit and holds until the next nibble. The bit carrying `inSof` is always bit 3 of a nibble.
- R8: Nibble mode: `frameInd` is 1 for the whole nibble period when the nibble on `nibData` starts with the frame-start bit, and 0 otherwise.
- R9: Nibble mode: `ohPin` is the OR of the nibble's four overhead flags when `cfgE3` = 1, and is held at 0 when `cfgE3` = 0. `cfgGapped` has no effect in nibble mode.
- R10: Nibble mode: `dataClk` goes to 1 on the edge that loads a nibble, stays 1 for four cycles, and is then 0 until the next load.
- R11: Nibble mode: a frame-start flag that arrives in the middle of a nibble discards the partial nibble and starts a new one at that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgE3 | input | 1 | 1 = E3 framing, 0 = DS3 framing |
| cfgNibble | input | 1 | 1 = nibble bus, 0 = serial output |
| cfgGapped | input | 1 | 1 = shared pin carries gapped payload clock (serial mode) |
| inValid | input | 1 | One-cycle strobe marking a new input bit |
| inBit | input | 1 | Received bit value |
| inOh | input | 1 | 1 when the bit is overhead |
| inSof | input | 1 | 1 on the first bit of a frame |
| serData | output | 1 | Serial data output |
| nibData | output | NIB_W | Nibble data output, earliest bit in the MSB |
| frameInd | output | 1 | Start-of-frame indicator |
| ohPin | output | 1 | Overhead indicator or gapped payload clock |
| dataClk | output | 1 | Output bit clock (serial) or nibble clock (nibble) |

## Verification
The checker watches several behaviours on every cycle. It confirms that all outputs stay quiet before the first frame start. In serial mode it checks that the serial data, frame indicator and overhead flag follow the captured bit one edge later, and that the gapped pulse is present for payload bits and absent for overhead bits and second half-periods. It also checks that the shared pin stays low for DS3 in nibble mode and that the serial line is frozen while the nibble bus is in use. Other behaviours are only visible over long stimulus and are shown by the bench's scenarios: the bit order inside a nibble, the nibble frame and overhead flags across whole DS3 and E3 frames, the four-cycle nibble clock, and realignment when a frame start lands mid-nibble.

// File: rtl/rx_payload_out_pkg.sv
`timescale 1ns/1ps
package rx_payload_out_pkg;

  // Strobes sent from the control section to the datapath.
  typedef struct packed {
    logic serLoad;     // accepted bit in serial mode
    logic nibShift;    // accepted bit in nibble mode
    logic nibFirst;    // accepted bit is the first of a nibble
    logic nibLoad;     // accepted bit completes a nibble
    logic nibClkFall;  // nibble clock high phase is over
  } ctrlStrobe_t;

endpackage

// File: rtl/rx_payload_ctrl.sv
`timescale 1ns/1ps
module rx_payload_ctrl
  import rx_payload_out_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int NIB_CLK_HI = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgNibble,
  input  logic        inValid,
  input  logic        inSof,
  output ctrlStrobe_t strobe
);

  localparam int POS_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam int CNT_W = $clog2(NIB_CLK_HI + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NIB_W - 1);
  localparam logic [CNT_W-1:0] HI_END   = CNT_W'(NIB_CLK_HI);

  logic             locked;
  logic             accept;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] effPos;
  logic [CNT_W-1:0] hiCnt;

  // A frame start always opens a new nibble.
  always_comb begin
    accept            = inValid && (locked || inSof);
    effPos            = inSof ? '0 : pos;
    strobe.serLoad    = accept && !cfgNibble;
    strobe.nibShift   = accept && cfgNibble;
    strobe.nibFirst   = (effPos == '0);
    strobe.nibLoad    = accept && cfgNibble && (effPos == LAST_POS);
    strobe.nibClkFall = (hiCnt == HI_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b0;
      pos    <= '0;
      hiCnt  <= '0;
    end else begin
      if (inValid && inSof) locked <= 1'b1;
      if (accept) pos <= (effPos == LAST_POS) ? '0 : effPos + 1'b1;
      if (strobe.nibLoad)       hiCnt <= CNT_W'(1);
      else if (hiCnt == HI_END) hiCnt <= '0;
      else if (hiCnt != '0)     hiCnt <= hiCnt + 1'b1;
    end
  end

endmodule

// File: rtl/rx_payload_dp.sv
`timescale 1ns/1ps
module rx_payload_dp
  import rx_payload_out_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgE3,
  input  logic             cfgNibble,
  input  logic             cfgGapped,
  input  logic             inBit,
  input  logic             inOh,
  input  logic             inSof,
  input  ctrlStrobe_t      strobe,
  output logic             serData,
  output logic [NIB_W-1:0] nibData,
  output logic             frameInd,
  output logic             ohPin,
  output logic             dataClk
);

  localparam int SH_W = NIB_W - 1;

  logic [SH_W-1:0] shReg;
  logic            ohAcc;
  logic            sofAcc;
  logic            nibOhAll;
  logic            nibSof;

  always_comb begin
    nibOhAll = strobe.nibFirst ? inOh : (ohAcc || inOh);
    nibSof   = strobe.nibFirst ? inSof : sofAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serData  <= 1'b0;
      nibData  <= '0;
      frameInd <= 1'b0;
      ohPin    <= 1'b0;
      dataClk  <= 1'b0;
      shReg    <= '0;
      ohAcc    <= 1'b0;
      sofAcc   <= 1'b0;
    end else begin
      // serial path: data and flags for a full bit period, clocks for half
      if (strobe.serLoad) begin
        serData  <= inBit;
        frameInd <= inSof;
        ohPin    <= cfgGapped ? !inOh : inOh;
        dataClk  <= 1'b1;
      end else if (!cfgNibble) begin
        dataClk <= 1'b0;
        if (cfgGapped) ohPin <= 1'b0;
      end
      // nibble path: older bits migrate toward the MSB
      if (strobe.nibShift) begin
        shReg  <= {shReg[SH_W-2:0], inBit};
        ohAcc  <= nibOhAll;
        sofAcc <= nibSof;
      end
      if (strobe.nibLoad) begin
        nibData  <= {shReg, inBit};
        frameInd <= nibSof;
        ohPin    <= cfgE3 && nibOhAll;
        dataClk  <= 1'b1;
      end else if (strobe.nibClkFall) begin
        dataClk <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_payload_out.sv
`timescale 1ns/1ps
module rx_payload_out
  import rx_payload_out_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int NIB_CLK_HI = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgE3,
  input  logic             cfgNibble,
  input  logic             cfgGapped,
  input  logic             inValid,
  input  logic             inBit,
  input  logic             inOh,
  input  logic             inSof,
  output logic             serData,
  output logic [NIB_W-1:0] nibData,
  output logic             frameInd,
  output logic             ohPin,
  output logic             dataClk
);

  ctrlStrobe_t strobe;

  rx_payload_ctrl #(.NIB_W(NIB_W), .NIB_CLK_HI(NIB_CLK_HI)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgNibble(cfgNibble),
    .inValid  (inValid),
    .inSof    (inSof),
    .strobe   (strobe)
  );

  rx_payload_dp #(.NIB_W(NIB_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgE3    (cfgE3),
    .cfgNibble(cfgNibble),
    .cfgGapped(cfgGapped),
    .inBit    (inBit),
    .inOh     (inOh),
    .inSof    (inSof),
    .strobe   (strobe),
    .serData  (serData),
    .nibData  (nibData),
    .frameInd (frameInd),
    .ohPin    (ohPin),
    .dataClk  (dataClk)
  );

endmodule

// File: rtl/rx_payload_out_chk.sv
`timescale 1ns/1ps
module rx_payload_out_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgE3,
  input logic             cfgNibble,
  input logic             cfgGapped,
  input logic             inValid,
  input logic             inBit,
  input logic             inOh,
  input logic             inSof,
  input logic             serData,
  input logic [NIB_W-1:0] nibData,
  input logic             frameInd,
  input logic             ohPin,
  input logic             dataClk
);

  logic seen;
  logic acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 seen <= 1'b0;
    else if (inValid && inSof) seen <= 1'b1;
  end

  assign acc = inValid && (seen || inSof);

  assert_quiet_before_sof_R2: assert property (@(posedge clk) disable iff (!rstN)
    !seen |-> (!ohPin && !dataClk && !frameInd && !serData && nibData == '0));

  assert_ser_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNibble && acc) |=> (serData == $past(inBit) && dataClk));

  assert_ser_clk_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNibble && !inValid) |=> !dataClk);

  assert_ser_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNibble && acc) |=> (frameInd == $past(inSof)));

  assert_ser_oh_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNibble && !cfgGapped && acc) |=> (ohPin == $past(inOh)));

  assert_gap_payload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNibble && cfgGapped && acc) |=> (ohPin == !$past(inOh)));

  assert_gap_low_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgNibble && cfgGapped && !inValid) |=> !ohPin);

  assert_nib_ser_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgNibble |=> $stable(serData));

  assert_ds3_nib_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgNibble && !cfgE3) |-> !ohPin);

endmodule

bind rx_payload_out rx_payload_out_chk #(.NIB_W(NIB_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cfgE3    (cfgE3),
  .cfgNibble(cfgNibble),
  .cfgGapped(cfgGapped),
  .inValid  (inValid),
  .inBit    (inBit),
  .inOh     (inOh),
  .inSof    (inSof),
  .serData  (serData),
  .nibData  (nibData),
  .frameInd (frameInd),
  .ohPin    (ohPin),
  .dataClk  (dataClk)
);

// File: tb/rx_payload_out_tb.sv
`timescale 1ns/1ps
module rx_payload_out_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgE3 = 1'b0, cfgNibble = 1'b0, cfgGapped = 1'b0;
  logic       inValid = 1'b0, inBit = 1'b0, inOh = 1'b0, inSof = 1'b0;
  logic       serData, frameInd, ohPin, dataClk;
  logic [3:0] nibData;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  // reference model state
  bit       mLocked;
  int       mPos;
  logic [3:0] mAcc;
  bit       mOhAcc, mSofAcc, mLoaded, mRealign, mLoadNow;
  int       mSince;
  logic     expSer, expFrame, expPin1, expPin2;
  logic [3:0] expNib;

  always #2.5 clk = ~clk;

  rx_payload_out dut_i (
    .clk(clk), .rstN(rstN), .cfgE3(cfgE3), .cfgNibble(cfgNibble),
    .cfgGapped(cfgGapped), .inValid(inValid), .inBit(inBit), .inOh(inOh),
    .inSof(inSof), .serData(serData), .nibData(nibData), .frameInd(frameInd),
    .ohPin(ohPin), .dataClk(dataClk)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input bit e3, input bit nib, input bit gap);
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; inSof = 1'b0; inOh = 1'b0; inBit = 1'b0;
    cfgE3 = e3; cfgNibble = nib; cfgGapped = gap;
    repeat (2) @(negedge clk);
    chk("R1 serData", {3'b0, serData}, 4'h0);
    chk("R1 nibData", nibData, 4'h0);
    chk("R1 frameInd", {3'b0, frameInd}, 4'h0);
    chk("R1 ohPin", {3'b0, ohPin}, 4'h0);
    chk("R1 dataClk", {3'b0, dataClk}, 4'h0);
    rstN = 1'b1;
    mLocked = 0; mPos = 0; mAcc = '0; mOhAcc = 0; mSofAcc = 0;
    mLoaded = 0; mRealign = 0; mSince = 100;
    expSer = 0; expFrame = 0; expPin1 = 0; expPin2 = 0; expNib = '0;
  endtask

  task automatic nibSample();
    bit clkExp;
    clkExp = mLoaded && (mSince < 4);
    chk("R10 nibble dataClk", {3'b0, dataClk}, {3'b0, clkExp});
    chk(mRealign && mLoadNow ? "R11 realigned nibble" : "R7 nibData", nibData, expNib);
    chk("R8 nibble frameInd", {3'b0, frameInd}, {3'b0, expFrame});
    chk("R9 nibble ohPin", {3'b0, ohPin}, {3'b0, expPin1});
    mSince++;
  endtask

  // Caller is at a negedge; returns at a negedge two cycles later.
  task automatic sendBit(input logic b, input logic oh, input logic sof);
    bit acc;
    int p;
    inValid = 1'b1; inBit = b; inOh = oh; inSof = sof;
    if (sof) mLocked = 1;
    acc = mLocked;
    mLoadNow = 0;
    if (acc && !cfgNibble) begin
      expSer = b; expFrame = sof;
      expPin1 = cfgGapped ? !oh : oh;
      expPin2 = cfgGapped ? 1'b0 : oh;
    end else if (acc && cfgNibble) begin
      if (sof && mPos != 0) mRealign = 1;
      p = sof ? 0 : mPos;
      if (p == 0) begin mOhAcc = oh; mSofAcc = sof; end
      else mOhAcc = mOhAcc | oh;
      mAcc = {mAcc[2:0], b};
      if (p == 3) begin
        expNib = mAcc; expFrame = mSofAcc; expPin1 = cfgE3 & mOhAcc;
        mLoaded = 1; mSince = 0; mLoadNow = 1;
      end
      mPos = (p + 1) % 4;
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
    if (!cfgNibble) begin
      if (!acc) begin
        chk("R2 ignored dataClk", {3'b0, dataClk}, 4'h0);
        chk("R2 ignored ohPin", {3'b0, ohPin}, 4'h0);
        chk("R2 ignored serData", {3'b0, serData}, 4'h0);
      end else begin
        chk("R3 serData", {3'b0, serData}, {3'b0, expSer});
        chk("R3 dataClk high", {3'b0, dataClk}, 4'h1);
        chk("R4 frameInd", {3'b0, frameInd}, {3'b0, expFrame});
        chk(cfgGapped ? "R6 gapped pulse" : "R5 overhead flag", {3'b0, ohPin}, {3'b0, expPin1});
      end
    end else begin
      if (!acc) chk("R2 ignored nibble frameInd", {3'b0, frameInd}, 4'h0);
      nibSample();
    end
    @(negedge clk);
    if (!cfgNibble) begin
      chk("R3 serData hold", {3'b0, serData}, {3'b0, acc ? expSer : 1'b0});
      chk("R3 dataClk low", {3'b0, dataClk}, 4'h0);
      chk("R4 frameInd hold", {3'b0, frameInd}, {3'b0, acc ? expFrame : 1'b0});
      chk(cfgGapped ? "R6 gapped low half" : "R5 overhead hold",
          {3'b0, ohPin}, {3'b0, acc ? expPin2 : 1'b0});
    end else begin
      nibSample();
      if (mLoadNow) mRealign = 0;
    end
  endtask

  task automatic runFrames(input bit e3, input int nFrames, input int preBits);
    int len;
    len = e3 ? 1536 : 4760;
    for (int i = 0; i < preBits; i++) sendBit($urandom % 2, $urandom % 2, 1'b0);
    for (int f = 0; f < nFrames; f++)
      for (int i = 0; i < len; i++)
        sendBit($urandom % 2, e3 ? (i < 12) : (i % 85 == 0), i == 0);
  endtask

  task automatic runRandom(input int nBits);
    sendBit($urandom % 2, $urandom % 2, 1'b1);
    for (int i = 0; i < nBits; i++)
      sendBit($urandom % 2, ($urandom % 8) == 0, ($urandom % 40) == 0);
  endtask

  initial begin
    void'($urandom(32'd20517));
    // serial, E3, flag on pin; leading bits must be ignored (R2)
    doReset(1, 0, 0); runFrames(1, 2, 12);
    // serial, E3, gapped clock (R6)
    doReset(1, 0, 1); runFrames(1, 2, 6);
    // serial, DS3, gapped then flag
    doReset(0, 0, 1); runFrames(0, 1, 4);
    doReset(0, 0, 0); runFrames(0, 1, 3);
    // nibble, E3 with gapped set (no effect, R9)
    doReset(1, 1, 1); runFrames(1, 2, 7);
    // nibble, DS3: pin held low (R9)
    doReset(0, 1, 0); runFrames(0, 1, 5);
    // directed realignment R11: frame start after two bits of a nibble
    doReset(1, 1, 0);
    sendBit(1, 1, 1); sendBit(0, 0, 0); sendBit(1, 0, 0); sendBit(1, 0, 0);
    sendBit(1, 0, 0); sendBit(1, 0, 0);
    sendBit(0, 0, 1); sendBit(1, 0, 0); sendBit(0, 1, 0); sendBit(1, 0, 0);
    chk("R11 directed nibble", nibData, 4'h5);
    chk("R11 directed frame", {3'b0, frameInd}, 4'h1);
    // random streams with frequent frame starts
    doReset(1, 1, 0); runRandom(1500);
    doReset(0, 0, 1); runRandom(1500);
    doReset(1, 0, 0); runRandom(1000);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule